// File: doc/BRIEF.md
# Interrupt Request Combiner with Selectable Pin Signalling

This block gathers fifteen independent status flags of a network controller into a single interrupt request line. Each flag is set by a one-cycle event pulse from its source. It stays set until software writes a one to its bit position. Every flag has one suppression control bit. A fixed parameter vector decides how each bit is read. For an enable-style source, a control bit of one lets the flag through. For a mask-style source, a control bit of one blocks it.

The allowed flags are ORed into a combined request. A registered summary bit mirrors that request in every output style. The interrupt pin is modelled as an output-enable plus a data value.

- **Default style:** the pin is an open-drain, active-low line. It drives low while a request is pending and is released otherwise.
- **Edge style:** selected by a configuration bit. The pin is driven continuously and shows a one-cycle high pulse each time the combined request rises.
- **Reset:** while reset is high the output-enable is forced off, so the pin acts as an input.

Top module: `irq_combiner`

## Requirements
- R1: A one on bit i of `evt_i` at a clock edge makes `flags_o[i]` read one after that edge. It stays one until it is cleared.
- R2: A clear write (`clr_wr_i` high) zeroes exactly the flags whose `clr_data_i` bit is one. Bits written zero are left unchanged.
- R3: If an event and a clear hit the same flag at the same edge, the flag remains set.
- R4: The control register `ctl_o` resets to all zeros and loads `ctl_data_i` on `ctl_wr_i`. Flag i is allowed when ENA_STYLE[i]=1 and ctl bit i=1, or when ENA_STYLE[i]=0 and ctl bit i=0. The default ENA_STYLE is 15'h001F, so bits 0..4 are enable-style and bits 5..14 are mask-style.
- R5: `summary_o` equals, one edge later, the OR over all flags of (flag AND allowed), in either output style.
- R6: With `edge_mode_i`=0 (open-drain style), `irq_oe_o` equals `summary_o` and `irq_do_o` is 0.
- R7: With `edge_mode_i`=1 (edge style), `irq_oe_o` is 1. `irq_do_o` is 1 for exactly the cycle in which `summary_o` goes from 0 to 1, and is 0 otherwise.
- R8: While `rst` is high, `irq_oe_o` is 0. After a reset edge, flags, control, summary and the pin data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also switches the pin to input |
| evt_i | input | 15 | One-cycle set pulses, one per flag |
| clr_wr_i | input | 1 | Write strobe for the write-one-to-clear flag register |
| clr_data_i | input | 15 | Write data; ones clear the matching flags |
| ctl_wr_i | input | 1 | Write strobe for the suppression control register |
| ctl_data_i | input | 15 | New suppression control value |
| edge_mode_i | input | 1 | 0 = open-drain active-low level, 1 = active-high edge pulse |
| flags_o | output | 15 | Current flag state |
| ctl_o | output | 15 | Current suppression control value |
| summary_o | output | 1 | Registered combined request after suppression |
| irq_oe_o | output | 1 | Pin output-enable |
| irq_do_o | output | 1 | Pin data value while enabled |

## Verification
The bench aims at the cases where a design most easily slips.

- **Set and clear at the same edge:** a design with the wrong priority drops the new event.
- **Polarity at the style boundary:** flags sit on both sides of the enable/mask split. Misreading one style lets blocked flags raise the pin, or hides allowed ones.
- **Entering edge style with a request already pending:** a design that keys its pulse on the mode change instead of the request edge emits a spurious pulse here. A held request that keeps pulsing would show the same fault.
- **Reset in mid-run:** an output-enable that is only registered keeps driving the pin for a cycle while reset is high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_NSRC = 15;

  typedef enum logic {
    DRV_OPEN_DRAIN = 1'b0,
    DRV_EDGE_HIGH  = 1'b1
  } drv_mode_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NSRC = irq_pkg::IRQ_NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_data,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] clr_mask;

  assign clr_mask = clr_wr ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_mask) | evt;
  end

  assign flags = flags_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

  // R2
  clr_only_written_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((flags_q & $past(clr_data & ~evt)) == '0));
endmodule

// File: rtl/irq_suppress.sv
module irq_suppress #(
  parameter int unsigned          NSRC      = irq_pkg::IRQ_NSRC,
  parameter logic [NSRC-1:0]      ENA_STYLE = NSRC'(5'h1F)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [NSRC-1:0] ctl_data,
  output logic [NSRC-1:0] ctl,
  output logic [NSRC-1:0] allow
);
  logic [NSRC-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_data;
  end

  assign ctl = ctl_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (ENA_STYLE[i]) begin : g_enable
      assign allow[i] = ctl_q[i];
    end else begin : g_mask
      assign allow[i] = ~ctl_q[i];
    end
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic edge_mode,
  output logic summary,
  output logic pin_oe,
  output logic pin_do
);
  drv_mode_e mode;
  logic sum_q, oe_q, do_q;

  assign mode = drv_mode_e'(edge_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= 1'b0;
      oe_q  <= 1'b0;
      do_q  <= 1'b0;
    end else begin
      sum_q <= req;
      case (mode)
        DRV_EDGE_HIGH: begin
          oe_q <= 1'b1;
          do_q <= req & ~sum_q;
        end
        default: begin
          oe_q <= req;
          do_q <= 1'b0;
        end
      endcase
    end
  end

  assign summary = sum_q;
  assign pin_oe  = oe_q & ~rst;
  assign pin_do  = do_q;

  // R7
  edge_pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    do_q |-> (sum_q && !$past(sum_q)));

  // R6
  level_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_mode |=> (!do_q && oe_q == sum_q));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int unsigned     NSRC      = irq_pkg::IRQ_NSRC,
  parameter logic [NSRC-1:0] ENA_STYLE = NSRC'(5'h1F)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_data_i,
  input  logic            ctl_wr_i,
  input  logic [NSRC-1:0] ctl_data_i,
  input  logic            edge_mode_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] ctl_o,
  output logic            summary_o,
  output logic            irq_oe_o,
  output logic            irq_do_o
);
  logic [NSRC-1:0] flags, allow;
  logic            req;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_i), .clr_wr(clr_wr_i),
    .clr_data(clr_data_i), .flags(flags)
  );

  irq_suppress #(.NSRC(NSRC), .ENA_STYLE(ENA_STYLE)) u_supp (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr_i), .ctl_data(ctl_data_i),
    .ctl(ctl_o), .allow(allow)
  );

  assign req = |(flags & allow);

  irq_pin_drive u_pin (
    .clk(clk), .rst(rst), .req(req), .edge_mode(edge_mode_i),
    .summary(summary_o), .pin_oe(irq_oe_o), .pin_do(irq_do_o)
  );

  assign flags_o = flags;

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (flags_o == '0 && ctl_o == '0 && !summary_o && !irq_do_o));
endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;
  localparam int N = 15;
  localparam logic [N-1:0] ENA = 15'h001F;

  logic clk = 0, rst = 1;
  logic [N-1:0] evt = '0, clr_data = '0, ctl_data = '0;
  logic clr_wr = 0, ctl_wr = 0, edge_mode = 0;
  logic [N-1:0] flags_o, ctl_o;
  logic summary_o, irq_oe_o, irq_do_o;

  int vectors = 0, fails = 0, cyc = 0;
  logic done = 0;

  logic [N-1:0] m_flags = '0, m_ctl = '0;
  logic m_sum = 0, m_oe = 0, m_do = 0;

  always #5 clk = ~clk;

  irq_combiner u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data), .edge_mode_i(edge_mode),
    .flags_o(flags_o), .ctl_o(ctl_o), .summary_o(summary_o),
    .irq_oe_o(irq_oe_o), .irq_do_o(irq_do_o)
  );

  always @(posedge clk) begin
    logic [N-1:0] nf;
    logic req;
    if (rst) begin
      m_flags = '0; m_ctl = '0; m_sum = 0; m_oe = 0; m_do = 0;
    end else begin
      req = 0;
      for (int i = 0; i < N; i++)
        if (m_flags[i] && (ENA[i] ? m_ctl[i] : !m_ctl[i])) req = 1;
      nf = m_flags;
      for (int i = 0; i < N; i++) begin
        if (clr_wr && clr_data[i]) nf[i] = 0;
        if (evt[i]) nf[i] = 1;
      end
      m_do  = edge_mode && req && !m_sum;
      m_oe  = edge_mode ? 1'b1 : req;
      m_sum = req;
      m_flags = nf;
      if (ctl_wr) m_ctl = ctl_data;
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R1 R2 R3 flags", flags_o, m_flags);
    chk("R4 ctl", ctl_o, m_ctl);
    chk("R5 summary", N'(summary_o), N'(m_sum));
    chk(edge_mode ? "R7 oe" : "R6 oe", N'(irq_oe_o), N'(m_oe && !rst));
    chk(edge_mode ? "R7 do" : "R6 do", N'(irq_do_o), N'(m_do));
    if (rst) chk("R8 oe in reset", N'(irq_oe_o), '0);
  end

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk); #2;
      evt = '0; clr_wr = 0; ctl_wr = 0;
    end
  endtask

  task automatic fire(logic [N-1:0] e);
    evt = e; step();
  endtask

  task automatic clear(logic [N-1:0] c, logic [N-1:0] e = '0);
    clr_wr = 1; clr_data = c; evt = e; step();
  endtask

  task automatic setctl(logic [N-1:0] c);
    ctl_wr = 1; ctl_data = c; step();
  endtask

  initial begin
    logic [15:0] lfsr;
    step(3);
    rst = 0;
    #1;
    chk("R8 flags after reset", flags_o, '0);
    chk("R8 summary after reset", N'(summary_o), '0);
    step();
    // R4: enable-style blocked at reset, mask-style allowed
    fire(15'h0001); step(2);
    chk("R4 enable-style blocked", N'(summary_o), '0);
    fire(15'h0020); step(2);
    chk("R4 mask-style allowed", N'(summary_o), 1);
    chk("R6 oe asserted", N'(irq_oe_o), 1);
    setctl(15'h0021); step(2);
    chk("R4 mask blocks, enable allows", N'(summary_o), 1);
    clear(15'h0001); step(2);
    chk("R2 flag0 cleared", flags_o, 15'h0020);
    chk("R5 only masked flag left", N'(summary_o), 0);
    // R3 set wins over clear
    clear(15'h0020, 15'h0020); step();
    chk("R3 set wins", flags_o & 15'h0020, 15'h0020);
    clear(15'h7FFF); step(2);
    // R7 edge mode with pending request: no pulse
    setctl(15'h0000); fire(15'h4000); step(3);
    edge_mode = 1; step(3);
    chk("R7 no pulse on mode change", N'(irq_do_o), 0);
    clear(15'h7FFF); step(3);
    fire(15'h0100); step();
    fire(15'h0200); step(3);
    clear(15'h7FFF); edge_mode = 0; step(2);
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evt = (lfsr[3:0] == 0) ? N'(1 << (lfsr[7:4] % N)) : '0;
      clr_wr = (lfsr[6:4] == 3);
      clr_data = N'({lfsr[9:0], lfsr[15:11]});
      ctl_wr = (lfsr[10:7] == 5);
      ctl_data = N'({lfsr[12:0], lfsr[15:14]});
      if (lfsr[15:11] == 7) edge_mode = ~edge_mode;
      rst = (k == 1500);
      @(posedge clk); #2;
      evt = '0; clr_wr = 0; ctl_wr = 0; rst = 0;
    end
    step(4);
    done = 1;
  end

  initial begin
    wait (done || cyc > 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule